// File: doc/BRIEF.md
# Four-Digit Decimal Seconds Counter

This block keeps a running count of elapsed seconds as four decimal digits: ones, tens, hundreds and thousands. It steps from 0000 up to 9999, then returns to 0000 and carries on. A prescaler divides the system clock down to one single-cycle enable per second. Each digit is its own modulo-ten counter. A digit advances on that enable only when every digit to its right is at 9, so each place runs at one tenth the rate of its right-hand neighbour.

The value is held directly in decimal form, so no binary-to-decimal conversion is needed. A display driver can take the four digit outputs as they are. A one-cycle wrap pulse marks the moment the count rolls from 9999 back to 0000.

The external reset is active low. It takes effect at once when asserted, and its release is re-timed to the clock through two flip-flops before it reaches the counting logic.

Top module: `seconds_bcd_counter`

## Requirements
- R1: While `rst_n` is low, all four digit outputs read 0 and `wrap_o` reads 0. This holds from the instant of assertion, without waiting for a clock edge.
- R2: After `rst_n` rises, the internal reset ends on the second rising clock edge. The first advance of the count then lands on rising edge TICK_CYCLES+2, counted from the release of `rst_n`.
- R3: Between advances, every output holds steady. Consecutive advances are exactly TICK_CYCLES clock cycles apart.
- R4: Every digit output is a 4-bit binary value in the range 0 to 9. Each advance raises the four-digit decimal value (thousands, hundreds, tens, ones) by exactly one.
- R5: The ones digit changes on every advance. Any higher digit changes only on an advance where every lower digit was 9; on that advance it increments, or wraps from 9 to 0.
- R6: An advance from 9999 gives 0000.
- R7: `wrap_o` is high for exactly one clock cycle: the first cycle in which 0000 is shown after a wrap from 9999. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; takes effect at once, release is re-timed to the clock |
| ones_o | output | 4 | Ones digit, binary 0 to 9 |
| tens_o | output | 4 | Tens digit, binary 0 to 9 |
| hundreds_o | output | 4 | Hundreds digit, binary 0 to 9 |
| thousands_o | output | 4 | Thousands digit, binary 0 to 9 |
| wrap_o | output | 1 | One-cycle pulse when the count rolls from 9999 to 0000 |

## Verification
The only input besides the clock is `rst_n`. The assertions assume that, once the re-timed reset has been released, the count starts from zero with the prescaler cleared. Every timing property is measured from that point.

The stimulus holds reset for at least one full clock. It releases reset only at a falling edge, so the two-flop re-timing gives a predictable release edge.

A reduced TICK_CYCLES lets one uninterrupted run pass through the full 9999-to-0000 wrap. Seeded random reset points and pulse widths then cut the count short at arbitrary phases of the prescaler and the digits.

// File: rtl/sec_counter_pkg.sv
// Package: shared widths and digit type for the seconds counter.
// Assumes decimal digits stored as plain 4-bit binary values.
package sec_counter_pkg;
    localparam int DIGIT_W    = 4;
    localparam int DIGIT_MAX  = 9;
    localparam int NUM_PLACES = 4;

    typedef logic [DIGIT_W-1:0] dec_digit_t;
endpackage

// File: rtl/sec_reset_sync.sv
// Module: reset re-timer. Assertion reaches the output at once;
// release passes through SYNC_STAGES flops so it lines up with clk.
// Assumes rst_n may change at any time relative to clk.
module sec_reset_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [SYNC_STAGES-1:0] chain_q;

    // Shift ones in after release; clear the chain the moment reset asserts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], 1'b1};
        end
    end

    assign rst_sync_n = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/sec_prescaler.sv
// Module: clock divider giving a one-cycle enable every TICK_CYCLES clocks.
// Assumes TICK_CYCLES >= 2. The first enable comes TICK_CYCLES-1 cycles
// after reset release, then one every TICK_CYCLES cycles.
module sec_prescaler #(
    parameter int TICK_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Count clocks, returning to zero after the last one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sec_decade_digit.sv
// Module: one modulo-ten decimal place. It advances when en is high and
// asserts carry when it is enabled while sitting at 9.
// Assumes en is a single-cycle pulse.
module sec_decade_digit
    import sec_counter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    output dec_digit_t value,
    output logic       carry
);
    localparam dec_digit_t TOP = dec_digit_t'(DIGIT_MAX);

    dec_digit_t value_q;

    assign carry = en && (value_q == TOP);
    assign value = value_q;

    // Step the digit on enable, wrapping from nine back to zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (carry) begin
            value_q <= '0;
        end else if (en) begin
            value_q <= value_q + 1'b1;
        end
    end
endmodule

// File: rtl/seconds_bcd_counter.sv
// Module: four-place decimal seconds counter, 0000 to 9999 with wrap.
// Assumes TICK_CYCLES is the clock frequency in Hz (smaller for simulation).
// Places chain their carries: each runs at a tenth of its right neighbour.
module seconds_bcd_counter
    import sec_counter_pkg::*;
#(
    parameter int TICK_CYCLES = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [3:0] ones_o,
    output logic [3:0] tens_o,
    output logic [3:0] hundreds_o,
    output logic [3:0] thousands_o,
    output logic       wrap_o
);
    logic       rst_sync_n;
    logic       tick;
    logic       chain [NUM_PLACES+1];
    dec_digit_t place [NUM_PLACES];
    logic       wrap_q;

    sec_reset_sync #(.SYNC_STAGES(2)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sync_n (rst_sync_n)
    );

    sec_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .tick  (tick)
    );

    assign chain[0] = tick;

    for (genvar i = 0; i < NUM_PLACES; i++) begin : g_place
        sec_decade_digit u_dig (
            .clk   (clk),
            .rst_n (rst_sync_n),
            .en    (chain[i]),
            .value (place[i]),
            .carry (chain[i+1])
        );
    end

    // Register the top carry so the pulse lines up with the 0000 display.
    always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= chain[NUM_PLACES];
        end
    end

    assign ones_o      = place[0];
    assign tens_o      = place[1];
    assign hundreds_o  = place[2];
    assign thousands_o = place[3];
    assign wrap_o      = wrap_q;
endmodule

// File: rtl/seconds_bcd_counter_chk.sv
// Checker: temporal properties of the seconds counter, bound to the top.
// Assumes the count and prescaler start from zero at internal reset release.
module seconds_bcd_counter_chk #(
    parameter int TICK_CYCLES = 50_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_sync_n,
    input logic       tick,
    input logic [3:0] ones,
    input logic [3:0] tens,
    input logic [3:0] hundreds,
    input logic [3:0] thousands,
    input logic       wrap
);
    logic [15:0] all_d;
    logic        nines;
    int          gap_q;

    assign all_d = {thousands, hundreds, tens, ones};
    assign nines = (ones == 4'd9) && (tens == 4'd9) && (hundreds == 4'd9) && (thousands == 4'd9);

    // Count cycles since the last enable, for the period check.
    always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) gap_q <= 0;
        else if (tick)   gap_q <= 0;
        else             gap_q <= gap_q + 1;
    end

    // R1: outputs are cleared whenever the external reset is low.
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (all_d == 16'h0 && !wrap)
                else $error("R1 reset state violated");
        end
    end

    assert_period_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        tick |-> (gap_q == TICK_CYCLES - 1));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !tick |=> $stable(all_d));

    assert_range_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (ones <= 4'd9) && (tens <= 4'd9) && (hundreds <= 4'd9) && (thousands <= 4'd9));

    assert_ones_step_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (tick && ones != 4'd9) |=> (ones == $past(ones) + 4'd1));

    assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (tick && ones != 4'd9) |=> $stable({thousands, hundreds, tens}));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (tick && nines) |=> (all_d == 16'h0 && wrap));

    assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
        wrap |-> (all_d == 16'h0));

    assert_wrap_single_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
        wrap |=> !wrap);
endmodule

bind seconds_bcd_counter seconds_bcd_counter_chk #(.TICK_CYCLES(TICK_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .tick       (tick),
    .ones       (ones_o),
    .tens       (tens_o),
    .hundreds   (hundreds_o),
    .thousands  (thousands_o),
    .wrap       (wrap_o)
);

// File: tb/tb_seconds_bcd_counter.sv
`timescale 1ns/1ps
// Bench: model-based checks of the seconds counter with seeded random resets.
module tb_seconds_bcd_counter;
    localparam int TICK = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ones, tens, hundreds, thousands;
    logic       wrap;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    seconds_bcd_counter #(.TICK_CYCLES(TICK)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ones_o      (ones),
        .tens_o      (tens),
        .hundreds_o  (hundreds),
        .thousands_o (thousands),
        .wrap_o      (wrap)
    );

    always #2 clk = ~clk;

    // Expected decimal value at cycle c after release (c = falling edges seen).
    function automatic int exp_value(int c);
        if (c < 2) return 0;
        return ((c - 2) / TICK) % 10000;
    endfunction

    // Expected wrap pulse at cycle c.
    function automatic bit exp_wrap(int c);
        if (c <= 2) return 1'b0;
        return ((c - 2) % TICK == 0) && (exp_value(c) == 0);
    endfunction

    function automatic int shown();
        return thousands * 1000 + hundreds * 100 + tens * 10 + ones;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Assert reset for width cycles and check outputs clear at once.
    task automatic apply_reset(int width);
        @(negedge clk);
        #0.5 rst_n = 1'b0;
        #0.5;
        check(shown() == 0 && !wrap, "R1 async clear", shown(), 0);
        for (int i = 0; i < width; i++) begin
            @(negedge clk);
            check(shown() == 0 && !wrap, "R1 held clear", shown(), 0);
        end
        rst_n = 1'b1;
    endtask

    // Run n cycles after release, checking every cycle against the model.
    task automatic run_span(int n);
        int prev_val = 0;
        int prev_d [4] = '{0, 0, 0, 0};
        bit first = 1'b1;
        for (int c = 1; c <= n; c++) begin
            int ev;
            int cur_d [4];
            @(negedge clk);
            ev = exp_value(c);
            cur_d = '{int'(ones), int'(tens), int'(hundreds), int'(thousands)};
            if (ev != exp_value(c - 1) && first) begin
                check(shown() == ev, "R2 first advance timing", shown(), ev);
                first = 1'b0;
            end else if (ev != exp_value(c - 1)) begin
                check(shown() == ev, "R4 advance by one", shown(), ev);
            end else begin
                check(shown() == ev, "R3 hold between advances", shown(), ev);
            end
            check(ones <= 9 && tens <= 9 && hundreds <= 9 && thousands <= 9,
                  "R4 digit range", shown(), ev);
            check(wrap == exp_wrap(c), "R7 wrap pulse", int'(wrap), int'(exp_wrap(c)));
            if (shown() != prev_val) begin
                for (int p = 1; p < 4; p++) begin
                    bit lower9 = 1'b1;
                    for (int q = 0; q < p; q++) if (prev_d[q] != 9) lower9 = 1'b0;
                    if (cur_d[p] != prev_d[p])
                        check(lower9, "R5 carry only after lower nines", cur_d[p], prev_d[p]);
                end
                check(cur_d[0] != prev_d[0], "R5 ones moves each advance", cur_d[0], prev_d[0]);
                if (prev_val == 9999)
                    check(shown() == 0, "R6 wrap to zero", shown(), 0);
            end
            prev_val = shown();
            prev_d = cur_d;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Directed: full run through the 9999 -> 0000 wrap.
        apply_reset(3);
        run_span(2 + 10000 * TICK + 40);
        // Directed: shortest reset pulse, then a span ending near an advance.
        apply_reset(1);
        run_span(2 + 7 * TICK - 1);
        // Random resets at arbitrary phases and widths.
        for (int s = 0; s < 8; s++) begin
            apply_reset(int'($urandom_range(1, 5)));
            run_span(int'($urandom_range(20, 2500)));
        end
        // Reset mid-count, then check the clear state.
        apply_reset(2);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule